// File: doc/BRIEF.md
# Bit-Stuffing Framed Serial Transmitter

This block turns a stream of bytes into a bit-oriented serial frame for a two-level line. Each frame starts with a delimiter byte, continues with the payload bits, and ends with a closing delimiter. Inside the payload, a 0 bit is inserted after every run of five 1 bits. Because of this insertion, the delimiter pattern can never appear in the payload. The delimiter itself is sent without insertion. The resulting bit stream is then line-coded so that every 0 bit (data, inserted or delimiter) flips the line level and every 1 bit leaves it unchanged.

Bytes arrive on a valid/ready port with start-of-frame and end-of-frame markers. The block sends one bit in each cycle where the bit-enable strobe is high, and it does nothing in any other cycle. Between frames it sends delimiters without a break.

A four-state machine controls the transmitter:
- **IDLE** sends delimiters.
- **DATA** sends payload bits.
- **STUFF** sends one inserted 0.
- **CLOSE** sends the closing delimiter.

The state changes as follows:
- **IDLE → DATA** or **CLOSE → DATA**: a flag has just ended and a start-marked byte is offered.
- **CLOSE → IDLE**: a flag has just ended and no start-marked byte is offered.
- **DATA → STUFF**: a payload bit completes a run of five 1s.
- **DATA → CLOSE**: the last bit of the end-marked byte is sent without completing a run.
- **STUFF → DATA**: the inserted bit is sent and more payload follows.
- **STUFF → CLOSE**: the inserted bit follows the last bit of the end-marked byte.

Top module: `hdlc_stuff_tx`

## Requirements
- R1: While reset is held, line_out is 1, busy is 0 and in_ready is 0.
- R2: Outside a frame, the line carries the delimiter 0x7E without a break, sent LSB first (bit order 0,1,1,1,1,1,1,0). The first delimiter starts at the first strobe after reset, and busy is 0 during these delimiters.
- R3: For each sent bit, line_out flips at the clock edge of its strobe if the bit is 0 and stays the same if the bit is 1.
- R4: In a cycle where bit_en is 0, in_ready is 0 and line_out does not change at the next edge.
- R5: Consider a byte with in_sof=1 that is valid when the last bit of a delimiter is sent. Its bits follow that delimiter directly, LSB first, with busy 1. busy goes high only at a strobed edge.
- R6: After five 1 payload bits in a row, the next bit sent is an inserted 0. The run count is cleared by every 0 bit, whether data or inserted. It also starts at zero in each frame: 1s from the previous frame or from delimiters do not count.
- R7: A payload byte is accepted (in_valid and in_ready both high) at the strobe that sends its bit 7. in_ready stays 0 while an inserted bit is being sent.
- R8: After the byte with in_eof=1, one closing delimiter 0x7E is sent with busy 1 and with no insertion. A start-marked byte offered at that point then begins the next frame directly.
- R9: A byte offered without in_sof outside a frame is accepted and dropped when a delimiter ends. The line keeps sending delimiters and busy stays 0.
- R10: A run of five 1s that ends on the last payload bit is followed by an inserted 0 before the closing delimiter.
- R11: Inside a frame's payload, the line never goes more than five sent bits without a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-time strobe; one line bit per high cycle |
| in_data | input | DATA_W | Payload byte, held stable while in_valid is high |
| in_valid | input | 1 | Byte offered |
| in_sof | input | 1 | Offered byte opens a frame |
| in_eof | input | 1 | Offered byte closes a frame |
| in_ready | output | 1 | Byte is taken at this edge when in_valid is high |
| line_out | output | 1 | Line level after zero-toggle coding |
| busy | output | 1 | High from the first payload bit to the end of the closing delimiter |

## Verification
The frames are chosen so that each one tests a different aspect of the stuffing:
- **0xA5**: a frame with no long runs, to confirm that nothing is inserted when it is not needed.
- **Two 0xFF bytes, then 0x00**: runs of 1s that cross byte boundaries, so that insertion points fall in the middle of a byte and shift the point where bytes are accepted.
- **0xF8**: a run that ends on the last payload bit, which must insert a 0 before the closing delimiter.
- **0x7E as data**: the delimiter pattern inside the payload, which must be broken up by an inserted 0.
- **A frame ending in 0xF0, directly followed by a frame starting with 0x01**: shows whether the run count leaks from one frame into the next.

Beyond the frame contents:
- A slow, one-in-three strobe pattern with long runs of 1s separates per-strobe behaviour from per-clock behaviour.
- Idle periods with a byte that has no start marker show whether such bytes are dropped or wrongly start a frame.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_STUFF = 2'd2,
        ST_CLOSE = 2'd3
    } tx_state_t;
endpackage

// File: rtl/hdlc_flag_gen.sv
`timescale 1ns/1ps
// Walks through the delimiter pattern one bit per advance, LSB first.
module hdlc_flag_gen #(
    parameter int              FLAG_W   = 8,
    parameter logic [FLAG_W-1:0] FLAG_PAT = 8'h7E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic flag_bit,
    output logic flag_last
);
    localparam int FIDX_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1;

    logic [FIDX_W-1:0] fidx;

    assign flag_bit  = FLAG_PAT[fidx];
    assign flag_last = (fidx == FIDX_W'(FLAG_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fidx <= '0;
        end else if (adv) begin
            fidx <= flag_last ? '0 : fidx + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_run_ctr.sv
`timescale 1ns/1ps
// Counts consecutive 1 bits and flags the bit that completes a run.
module hdlc_run_ctr #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic bit_val,
    output logic run_full
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    logic [CNT_W-1:0] cnt;

    assign run_full = adv && bit_val && (cnt == CNT_W'(RUN_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= bit_val ? cnt + 1'b1 : '0;
        end
    end
endmodule

// File: rtl/hdlc_nrzi_enc.sv
`timescale 1ns/1ps
// Zero-toggle line coder: a 0 flips the level, a 1 keeps it.
module hdlc_nrzi_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic bit_val,
    output logic line
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line <= 1'b1;
        end else if (adv && !bit_val) begin
            line <= ~line;
        end
    end
endmodule

// File: rtl/hdlc_stuff_tx.sv
`timescale 1ns/1ps
module hdlc_stuff_tx
    import hdlc_tx_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                RUN_LEN  = 5,
    parameter int                FLAG_W   = 8,
    parameter logic [FLAG_W-1:0] FLAG_PAT = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              in_ready,
    output logic              line_out,
    output logic              busy
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_t        state, state_nx;
    logic [IDX_W-1:0] idx, idx_nx;
    logic             close_pend, close_pend_nx;

    logic in_flag;
    logic byte_last;
    logic emit;
    logic cur_bit;
    logic flag_bit, flag_last;
    logic run_full;

    assign in_flag   = (state == ST_IDLE) || (state == ST_CLOSE);
    assign byte_last = (idx == IDX_W'(DATA_W - 1));

    hdlc_flag_gen #(.FLAG_W(FLAG_W), .FLAG_PAT(FLAG_PAT)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (bit_en && in_flag),
        .flag_bit (flag_bit),
        .flag_last(flag_last)
    );

    hdlc_run_ctr #(.RUN_LEN(RUN_LEN)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (in_flag),
        .adv     (emit && !in_flag),
        .bit_val (cur_bit),
        .run_full(run_full)
    );

    hdlc_nrzi_enc u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (emit),
        .bit_val(cur_bit),
        .line   (line_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            idx        <= '0;
            close_pend <= 1'b0;
        end else begin
            state      <= state_nx;
            idx        <= idx_nx;
            close_pend <= close_pend_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx      = state;
        idx_nx        = idx;
        close_pend_nx = close_pend;
        unique case (state)
            ST_IDLE, ST_CLOSE: begin
                if (bit_en && flag_last) begin
                    state_nx      = (in_valid && in_sof) ? ST_DATA : ST_IDLE;
                    idx_nx        = '0;
                    close_pend_nx = 1'b0;
                end
            end
            ST_DATA: begin
                if (bit_en && in_valid) begin
                    idx_nx = byte_last ? '0 : idx + 1'b1;
                    if (run_full) begin
                        state_nx      = ST_STUFF;
                        close_pend_nx = byte_last && in_eof;
                    end else if (byte_last && in_eof) begin
                        state_nx = ST_CLOSE;
                    end
                end
            end
            ST_STUFF: begin
                if (bit_en) begin
                    state_nx = close_pend ? ST_CLOSE : ST_DATA;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy = (state != ST_IDLE);
        unique case (state)
            ST_IDLE, ST_CLOSE: begin
                cur_bit  = flag_bit;
                emit     = bit_en;
                in_ready = bit_en && flag_last && !in_sof;
            end
            ST_DATA: begin
                cur_bit  = in_data[idx];
                emit     = bit_en && in_valid;
                in_ready = bit_en && byte_last;
            end
            ST_STUFF: begin
                cur_bit  = 1'b0;
                emit     = bit_en;
                in_ready = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hdlc_stuff_tx_chk.sv
`timescale 1ns/1ps
module hdlc_stuff_tx_chk
    import hdlc_tx_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input logic      clk,
    input logic      rst_n,
    input logic      bit_en,
    input logic      in_valid,
    input logic      in_ready,
    input logic      line_out,
    input logic      busy,
    input tx_state_t state
);
    localparam int CW = $clog2(RUN_LEN + 2) + 1;

    logic          pay_q, flg_q, lv_q;
    logic [CW-1:0] steady;

    // Counts sent payload bits since the last observed line transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pay_q  <= 1'b0;
            flg_q  <= 1'b0;
            lv_q   <= 1'b1;
            steady <= '0;
        end else begin
            pay_q <= bit_en && ((state == ST_STUFF) || (state == ST_DATA && in_valid));
            flg_q <= bit_en && ((state == ST_IDLE) || (state == ST_CLOSE));
            lv_q  <= line_out;
            if (flg_q) begin
                steady <= '0;
            end else if (pay_q) begin
                steady <= (line_out != lv_q) ? '0 : steady + 1'b1;
            end
        end
    end

    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(line_out)); // R4

    AST_STUFF_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STUFF) |-> !in_ready); // R7

    AST_STUFF_TOGGLES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && state == ST_STUFF) |=> (line_out != $past(line_out))); // R6

    AST_BUSY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bit_en)); // R5

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        steady <= CW'(RUN_LEN)); // R11
endmodule

bind hdlc_stuff_tx hdlc_stuff_tx_chk #(.RUN_LEN(RUN_LEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .line_out(line_out),
    .busy    (busy),
    .state   (state)
);

// File: tb/hdlc_stuff_tx_tb_top.sv
`timescale 1ns/1ps
module hdlc_stuff_tx_tb_top;
    localparam logic [7:0] FLAG = 8'h7E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       in_ready, line_out, busy;

    hdlc_stuff_tx dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_data(in_data),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready), .line_out(line_out), .busy(busy)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int tick_mode = 0;
    int phase = 0;

    always @(posedge clk) begin
        #1;
        phase  = (phase + 1) % 3;
        bit_en = (tick_mode == 1) || (tick_mode == 2 && phase == 0);
    end

    bit    expq[$];
    string tagq[$];
    int    accq[$];
    int    exp_pos  = 0;
    int    gb       = 0;
    int    discards = 0;
    logic [7:0] frm[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_bit(input bit v, input string t);
        expq.push_back(v);
        tagq.push_back(t);
        exp_pos++;
    endtask

    // Driver: expected stuffed stream, accept points, then the handshake.
    task automatic send_frame();
        int ones = 0;
        for (int i = 0; i < frm.size(); i++) begin
            for (int b = 0; b < 8; b++) begin
                push_bit(frm[i][b], "R3 R5 data bit");
                if (b == 7) accq.push_back(exp_pos - 1);
                ones = frm[i][b] ? ones + 1 : 0;
                if (ones == 5) begin
                    push_bit(1'b0, (i == frm.size() - 1 && b == 7) ? "R10 stuff before close" : "R6 R11 stuff bit");
                    ones = 0;
                end
            end
        end
        for (int b = 0; b < 8; b++) push_bit(FLAG[b], "R8 closing flag");
        for (int i = 0; i < frm.size(); i++) begin
            in_data  = frm[i];
            in_sof   = (i == 0);
            in_eof   = (i == frm.size() - 1);
            in_valid = 1'b1;
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk);
            #2;
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic wait_idle();
        while (expq.size() != 0 || busy) @(negedge clk);
        @(posedge clk);
        #2;
    endtask

    // Monitor: decodes the line per strobe and compares with the queue.
    logic pend = 1'b0, s_line = 1'b1, s_busy = 1'b0;
    logic held_valid = 1'b0, held_line = 1'b1;
    int   idle_pos = 0;

    initial begin
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (held_valid) chk(line_out == held_line, "R4 line held", int'(line_out), int'(held_line));
            held_valid = 1'b0;
            if (pend) begin
                bit b;
                b    = (line_out == s_line);
                pend = 1'b0;
                if (s_busy) begin
                    if (expq.size() == 0) chk(1'b0, "R5 unexpected busy bit", int'(b), -1);
                    else begin
                        bit e;
                        string t;
                        e = expq.pop_front();
                        t = tagq.pop_front();
                        chk(b == e, t, int'(b), int'(e));
                    end
                    idle_pos = 0;
                end else begin
                    chk(b == FLAG[idle_pos], "R2 idle flag bit", int'(b), int'(FLAG[idle_pos]));
                    idle_pos = (idle_pos + 1) % 8;
                end
            end
            if (bit_en) begin
                s_line = line_out;
                s_busy = busy;
                pend   = 1'b1;
                if (in_valid && in_ready) begin
                    if (busy) begin
                        if (accq.size() == 0) chk(1'b0, "R7 unexpected accept", gb, -1);
                        else begin
                            int a;
                            a = accq.pop_front();
                            chk(gb == a, "R7 accept position", gb, a);
                        end
                    end else begin
                        discards++;
                    end
                end
                if (busy) gb++;
            end else begin
                held_valid = 1'b1;
                held_line  = line_out;
                if (in_ready) chk(1'b0, "R4 ready without strobe", 1, 0);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #2;
                chk(line_out == 1'b1, "R1 reset line", int'(line_out), 1);
                chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
                chk(in_ready == 1'b0, "R1 reset ready", int'(in_ready), 0);
                rst_n = 1'b1;
                repeat (6) @(posedge clk);
                #2;
                tick_mode = 1;
                repeat (40) @(posedge clk);
                #2;
                frm = '{8'hA5};              send_frame(); wait_idle();
                frm = '{8'hFF, 8'hFF, 8'h00}; send_frame(); wait_idle();
                frm = '{8'hF8};              send_frame(); wait_idle();
                frm = '{8'h7E, 8'h3F};       send_frame(); wait_idle();
                frm = '{8'hF0};              send_frame();
                frm = '{8'h01, 8'h80};       send_frame(); wait_idle();
                tick_mode = 2;
                frm = '{8'hFF, 8'hFF, 8'hFF}; send_frame(); wait_idle();
                // R9: byte without start marker outside a frame
                in_data  = 8'h55;
                in_valid = 1'b1;
                forever begin
                    @(negedge clk);
                    if (in_ready) break;
                end
                @(posedge clk);
                #2;
                in_valid = 1'b0;
                repeat (60) @(posedge clk);
                #2;
                chk(discards == 1, "R9 discard count", discards, 1);
                chk(busy == 1'b0, "R9 busy after discard", int'(busy), 0);
                chk(expq.size() == 0, "R8 stream drained", expq.size(), 0);
                chk(accq.size() == 0, "R7 accepts drained", accq.size(), 0);
                tick_mode = 0;
                repeat (12) @(posedge clk);
                #2;
            end
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule